// File: doc/BRIEF.md
# Level Interrupt Aggregator with Split Mask Words

This block gathers 32 level-sensitive interrupt sources from a board controller and presents them to a host processor as one active-low level interrupt line. Each source is brought into the clock domain through a two-flop synchronizer. The synchronized levels can be read as two 16-bit status words. Software enables or disables each source through two 16-bit mask words. In these words a 1 blocks the source and a 0 lets it through.

The block sits on a simple 16-bit register bus with a select, a write strobe, a byte address and write data. A read returns its data, together with a valid flag, on the clock after the request. Source decoding is left to host software. The host reads both status words, clears the masked bits and services whatever remains. For this reason the block has no priority logic and no vector. Source 15 of the low word is normally wired to the Ethernet controller.

Top module: `irqc_top`

## Requirements
- R1: Status word 0 at offset 0x20 shows sources 0 to 15, with bit i = source i. Status word 1 at offset 0x22 shows sources 16 to 31, with bit i = source 16+i. Each bit equals the input level sampled two rising edges earlier.
- R2: Mask word 0 at offset 0x30 covers sources 0 to 15, and mask word 1 at offset 0x32 covers sources 16 to 31, with the same bit order as R1. A write replaces the whole word. A read returns the value last written.
- R3: A mask bit of 1 blocks its source. While every active source is blocked, `irq_n` stays high (1). Writing 0xFFFF to both mask words blocks every source.
- R4: A source is pending when its status bit is 1 and its mask bit is 0. `irq_n` is driven low (0) on the clock after any of the 32 pending bits is set, and high on the clock after none is set.
- R5: After reset both mask words read 0xFFFF, `irq_n` is 1 and `bus_rvalid` is 0.
- R6: Writes to the status offsets have no effect. The status words keep following the inputs and both mask words keep their values.
- R7: A read from any offset other than the four listed returns 0x0000. A write to such an offset changes no mask word.
- R8: `bus_rvalid` is 1 on exactly the clock after each read request (`bus_sel`=1, `bus_wr`=0) and 0 otherwise. `bus_rdata` is valid while `bus_rvalid` is 1.
- R9: `irq_n` follows a mask write on the second rising edge after the write is driven. It follows a change of a source input on the third rising edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 32 | Level interrupt sources, active high, asynchronous |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a read request |
| irq_n | output | 1 | Summary interrupt, active low, level |

## Verification
The bench goes after the word boundary by using sources 15 and 16. A swapped half or a reversed bit order would show up there as wrong status data or as the wrong source raising the line. It writes to the status offsets and to unmapped offsets, then reads the masks back. A decoder that aliased addresses would corrupt a mask or return non-zero data. It counts the exact edge on which `irq_n` moves after a source change and after a mask write. A missing or extra synchronizer stage would make the line move one edge early or one edge late. Mixed source and mask patterns catch an inverted mask sense, which would raise the line for blocked sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Number of bytes covered by one register word on the bus
  function automatic int unsigned word_bytes(input int unsigned word_w);
    return word_w / 8;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_sync_n = rst_q[1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = din;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned STAT_BASE = 32'h20,
  parameter int unsigned MASK_BASE = 32'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] stat_vec,
  output logic [NUM_SRC-1:0] mask_vec,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_rvalid
);
  import irqc_pkg::*;

  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W;
  localparam int unsigned STRIDE    = word_bytes(WORD_W);

  logic                 rd_req;
  logic                 wr_req;
  logic [NUM_WORDS-1:0] hit_stat;
  logic [NUM_WORDS-1:0] hit_mask;
  logic [NUM_WORDS-1:0] mask_en;
  logic [WORD_W-1:0]    mask_q [NUM_WORDS];
  logic [WORD_W-1:0]    mask_d [NUM_WORDS];
  logic [WORD_W-1:0]    rd_mux;
  logic [WORD_W-1:0]    rdata_q;
  logic                 rvalid_q;

  assign rd_req = bus_sel & ~bus_wr;
  assign wr_req = bus_sel &  bus_wr;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + w * STRIDE);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_BASE + w * STRIDE);

    assign hit_stat[w] = (bus_addr == STAT_ADDR);
    assign hit_mask[w] = (bus_addr == MASK_ADDR);
    assign mask_en[w]  = wr_req & hit_mask[w];
    assign mask_d[w]   = bus_wdata;

    // Mask word: all sources blocked out of reset (R5)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[w] <= '1;
      else if (mask_en[w]) mask_q[w] <= mask_d[w];
    end

    assign mask_vec[w*WORD_W +: WORD_W] = mask_q[w];
  end

  // Read mux: unmapped offsets yield zero (R7)
  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit_stat[w]) rd_mux = rd_mux | stat_vec[w*WORD_W +: WORD_W];
      if (hit_mask[w]) rd_mux = rd_mux | mask_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/irqc_combine.sv
module irqc_combine #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] stat_vec,
  input  logic [NUM_SRC-1:0] mask_vec,
  output logic               irq_n
);
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W;

  logic [NUM_WORDS-1:0] word_pend;
  logic                 any_pend;
  logic                 irq_n_d;
  logic                 irq_n_q;

  // One reduction per word, then a narrow OR across words
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_pend[w] = |(stat_vec[w*WORD_W +: WORD_W] & ~mask_vec[w*WORD_W +: WORD_W]);
  end

  assign any_pend = |word_pend;
  assign irq_n_d  = ~any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= irq_n_d;
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAT_BASE   = 32'h20,
  parameter int unsigned MASK_BASE   = 32'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_n
);
  logic               core_rst_n;
  logic [NUM_SRC-1:0] stat_vec;
  logic [NUM_SRC-1:0] mask_vec;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .din   (src_lvl),
    .dout  (stat_vec)
  );

  irqc_regs #(
    .NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .MASK_BASE(MASK_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .stat_vec   (stat_vec),
    .mask_vec   (mask_vec),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  irqc_combine #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_comb (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .stat_vec (stat_vec),
    .mask_vec (mask_vec),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned STAT_BASE = 32'h20,
  parameter int unsigned MASK_BASE = 32'h30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic [NUM_SRC-1:0] stat_vec,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic [WORD_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic               irq_n
);
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W;
  localparam int unsigned STRIDE    = WORD_W / 8;
  localparam logic [ADDR_W-1:0] MASK0 = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK1 = ADDR_W'(MASK_BASE + STRIDE);

  logic [1:0] cyc_q;
  logic       mapped;
  logic       mask_hit;
  logic       rd;
  logic       any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always_comb begin
    mapped   = 1'b0;
    mask_hit = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(STAT_BASE + w * STRIDE)) mapped = 1'b1;
      if (bus_addr == ADDR_W'(MASK_BASE + w * STRIDE)) begin
        mapped   = 1'b1;
        mask_hit = 1'b1;
      end
    end
  end

  assign rd       = bus_sel & ~bus_wr;
  assign any_pend = |(stat_vec & ~mask_vec);

  p_stat_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> (stat_vec == $past(src_lvl, 2)));

  p_mask_wr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == MASK0) |=> (mask_vec[WORD_W-1:0] == $past(bus_wdata)));

  p_mask_wr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == MASK1) |=> (mask_vec[2*WORD_W-1:WORD_W] == $past(bus_wdata)));

  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> irq_n);

  p_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> !irq_n);

  p_reset_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd0) |-> (mask_vec == '1 && irq_n && !bus_rvalid));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && mask_hit) |=> $stable(mask_vec));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> (bus_rdata == '0));

  p_rvalid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  p_rvalid_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
endmodule

bind irqc_top irqc_chk u_chk (
  .clk        (clk),
  .rst_n      (core_rst_n),
  .src_lvl    (src_lvl),
  .stat_vec   (stat_vec),
  .mask_vec   (mask_vec),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_n      (irq_n)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  localparam logic [15:0] A_STAT0 = 16'h0020;
  localparam logic [15:0] A_STAT1 = 16'h0022;
  localparam logic [15:0] A_MASK0 = 16'h0030;
  localparam logic [15:0] A_MASK1 = 16'h0032;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_lvl;
  logic        bus_sel;
  logic        bus_wr;
  logic [15:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_mask;

  always #5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq_n();
    return !(|(src_lvl & ~m_mask));
  endfunction

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: called at a falling edge, pushes the expected read value
  task automatic bus_read(input logic [15:0] addr, input logic [15:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] addr, input logic [15:0] data);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    if (addr == A_MASK0) m_mask[15:0]  = data;
    if (addr == A_MASK1) m_mask[31:16] = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Monitor: pops expected read data as the design returns it (R8)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {16'h0, bus_rdata}, {16'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; src_lvl = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; m_mask = '1;
    edges(3);
    check("R5 irq_n in reset", {31'h0, irq_n}, 32'd1);
    check("R5 rvalid in reset", {31'h0, bus_rvalid}, 32'd0);
    rst_n = 1'b1;
    edges(4);
    check("R5 irq_n after reset", {31'h0, irq_n}, 32'd1);

    // R5 / R2: masks reset to all ones
    bus_read(A_MASK0, 16'hFFFF, "R5 mask0 reset");
    bus_read(A_MASK1, 16'hFFFF, "R5 mask1 reset");
    edges(1);
    check("R8 rvalid idle", {31'h0, bus_rvalid}, 32'd0);

    // R1: boundary sources 0, 15 and 31
    src_lvl = 32'h8000_8001;
    edges(4);
    bus_read(A_STAT0, 16'h8001, "R1 status word 0");
    bus_read(A_STAT1, 16'h8000, "R1 status word 1");
    check("R3 all masked", {31'h0, irq_n}, 32'd1);

    // R4 / R9: unmask source 15, line follows on second edge
    bus_write(A_MASK0, 16'h7FFF);
    edges(1);
    check("R4 R9 src15 unmasked", {31'h0, irq_n}, 32'd0);
    bus_read(A_MASK0, 16'h7FFF, "R2 mask0 readback");

    // R3: reblock every source
    bus_write(A_MASK0, 16'hFFFF);
    edges(1);
    check("R3 reblocked", {31'h0, irq_n}, 32'd1);

    // R6: status writes ignored
    bus_write(A_STAT0, 16'h0000);
    bus_write(A_STAT1, 16'h1234);
    edges(1);
    bus_read(A_STAT0, 16'h8001, "R6 status0 after write");
    bus_read(A_STAT1, 16'h8000, "R6 status1 after write");
    bus_read(A_MASK0, 16'hFFFF, "R6 mask0 untouched");
    bus_read(A_MASK1, 16'hFFFF, "R6 mask1 untouched");

    // R7: unmapped offsets
    bus_read(16'h0024, 16'h0000, "R7 read 0x24");
    bus_read(16'h0031, 16'h0000, "R7 read 0x31");
    bus_read(16'h1030, 16'h0000, "R7 read 0x1030");
    bus_write(16'h0034, 16'h0000);
    bus_write(16'h0130, 16'h0000);
    edges(1);
    check("R7 irq after unmapped write", {31'h0, irq_n}, 32'd1);
    bus_read(A_MASK0, 16'hFFFF, "R7 mask0 after unmapped write");
    bus_read(A_MASK1, 16'hFFFF, "R7 mask1 after unmapped write");

    // R3: unmask source 16 while it is idle
    bus_write(A_MASK1, 16'hFFFE);
    edges(1);
    check("R3 unmasked idle source", {31'h0, irq_n}, 32'd1);

    // R9: source edge latency, three rising edges
    src_lvl[16] = 1'b1;
    edges(2);
    check("R9 not before third edge", {31'h0, irq_n}, 32'd1);
    edges(1);
    check("R9 src16 on third edge", {31'h0, irq_n}, 32'd0);
    src_lvl[16] = 1'b0;
    edges(2);
    check("R9 hold before release", {31'h0, irq_n}, 32'd0);
    edges(1);
    check("R4 R9 released", {31'h0, irq_n}, 32'd1);

    // R4: mixed patterns
    lf = 32'hACE1_1357;
    for (int k = 0; k < 8; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src_lvl = lf;
      bus_write(A_MASK0, lf[15:0] ^ 16'hA5F0 ^ 16'(k));
      bus_write(A_MASK1, lf[31:16] | 16'(k << 3));
      edges(3);
      check("R4 mixed pattern", {31'h0, irq_n}, {31'h0, exp_irq_n()});
      bus_read(A_STAT0, src_lvl[15:0], "R1 mixed status0");
      bus_read(A_STAT1, src_lvl[31:16], "R1 mixed status1");
    end

    edges(2);
    check("R8 no read left outstanding", exp_q.size(), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule